// File: doc/BRIEF.md
# Register-Transfer Control Sequencer

This block is a small microprogrammed controller. It drives an 18-line control word that moves data between a four-entry register bank and an accumulator over one shared bus. Every control line is active low and rests high. A one-cycle start pulse together with a one-bit opcode picks one of two three-step microsequences:

- copy the target register into the accumulator;
- copy the accumulator into the target register.

The sequencer presents one microword per clock. It then raises a one-cycle done flag and returns to idle.

In each sequence the bus enable and the latch strobe are released in the same step. This keeps every transfer to three steps. The capture happens on the falling edge of the strobe, one step after the bus source is enabled. A separate behavioural register bank with eight-bit entries is supplied next to the sequencer. Its capture behaviour and its bus-contention count can be checked against the control word.

Top module: `xfer_microseq`

## Requirements
- R1: While reset is low, and right after it is released, the control word is all ones, busy is 0 and done is 0.
- R2: While idle, with no start accepted, the control word stays all ones (18'h3FFFF).
- R3: Word bit positions run from bit 17 down to bit 0 in this order: C0..C3, ENA0..ENA3, ENX0..ENX3, S1..S6. With opcode 0 (load), the first step drives only ENA0 (bit 13) low, giving 18'h3DFFF.
- R4: In the second load step ENA0 stays low and S5 (bit 1) goes low, giving 18'h3DFFD.
- R5: The third step returns the word to all ones. The next cycle shows done=1 for exactly one cycle, and the cycle after that is idle with busy=0.
- R6: With opcode 1 (save), the first step drives only S6 (bit 0) low (18'h3FFFE). The second step also drives C0 (bit 17) low (18'h1FFFE).
- R7: Busy is high from the first step through the done cycle. Start pulses that arrive while busy have no effect on the word sequence.
- R8: The opcode is sampled only when start is accepted in idle. Changing it during a sequence does not change the words produced.
- R9: In the register bank, a falling S5 loads the accumulator from the bus. A load sequence therefore copies R0 into the accumulator and leaves R0 unchanged.
- R10: A falling Cn loads Rn from the bus. A save sequence therefore copies the accumulator into R0 and leaves the accumulator unchanged.
- R11: The bus never has more than one driver: register n drives it when ENAn is low, and the accumulator drives it when S6 is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a microsequence (accepted only when idle) |
| opcode | input | 1 | 0 = load accumulator from target, 1 = save accumulator to target |
| ctrl_n | output | 18 | Active-low control word, C0 at bit 17 through S6 at bit 0 |
| busy | output | 1 | Sequence in progress, including the done cycle |
| done | output | 1 | One-cycle pulse after the last step |

## Verification
A corrupted step state shows up in the very next cycle. It appears as a wrong control word, as a sequence that is one cycle too long or too short, or as done arriving at the wrong cycle. A stale or overwritten opcode latch shows up as the other sequence's word in the first step after start. In the register bank, a strobe fired one step early or late captures a floating or wrong bus value. That error is visible at the register outputs as soon as the sequence completes. For this reason every cycle of every sequence is compared against an expected queue, and the data contents are compared after each done.

// File: rtl/xfer_pkg.sv
`timescale 1ns/1ps
package xfer_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_FIN  = 3'd4
   } step_e;

   localparam int STROBE_COUNT = 6;

   // total word width for a bank of n registers
   function automatic int word_w(input int n);
      return 3 * n + STROBE_COUNT;
   endfunction

   // latch strobe of register i
   function automatic int pos_latch(input int n, input int i);
      return word_w(n) - 1 - i;
   endfunction

   // bus enable of register i
   function automatic int pos_drive(input int n, input int i);
      return word_w(n) - 1 - n - i;
   endfunction

   // auxiliary enable of register i (passive here)
   function automatic int pos_aux(input int n, input int i);
      return word_w(n) - 1 - 2 * n - i;
   endfunction

   // strobe k, k = 1..6
   function automatic int pos_strobe(input int k);
      return STROBE_COUNT - k;
   endfunction

endpackage

// File: rtl/xfer_microstore.sv
`timescale 1ns/1ps
module xfer_microstore
   import xfer_pkg::*;
#(
   parameter int NUM_REGS = 4,
   parameter int TARGET   = 0,
   localparam int CW      = 3 * NUM_REGS + STROBE_COUNT
) (
   input  step_e          step,
   input  logic           op,
   output logic [CW-1:0]  word_n
);

   localparam int ACC_LATCH = pos_strobe(5);
   localparam int ACC_DRIVE = pos_strobe(6);
   localparam int TGT_LATCH = pos_latch(NUM_REGS, TARGET);
   localparam int TGT_DRIVE = pos_drive(NUM_REGS, TARGET);

   generate
      if (TARGET < 0 || TARGET >= NUM_REGS) begin : g_bad_target
         $error("TARGET must index an existing register");
      end
      if (NUM_REGS < 1) begin : g_bad_regs
         $error("NUM_REGS must be at least one");
      end
   endgenerate

   // per-step microword; lines not named stay released
   always_comb begin
      word_n = '1;
      unique case (step)
         ST_T1: begin
            if (op) word_n[ACC_DRIVE] = 1'b0;
            else    word_n[TGT_DRIVE] = 1'b0;
         end
         ST_T2: begin
            if (op) begin
               word_n[ACC_DRIVE] = 1'b0;
               word_n[TGT_LATCH] = 1'b0;
            end else begin
               word_n[TGT_DRIVE] = 1'b0;
               word_n[ACC_LATCH] = 1'b0;
            end
         end
         default: word_n = '1;
      endcase
   end

endmodule

// File: rtl/xfer_stepper.sv
`timescale 1ns/1ps
module xfer_stepper
   import xfer_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   input  logic  op,
   output step_e step,
   output logic  op_q,
   output logic  busy,
   output logic  done
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step <= ST_IDLE;
         op_q <= 1'b0;
      end else begin
         unique case (step)
            ST_IDLE: if (start) begin
               step <= ST_T1;
               op_q <= op;
            end
            ST_T1:   step <= ST_T2;
            ST_T2:   step <= ST_T3;
            ST_T3:   step <= ST_FIN;
            ST_FIN:  step <= ST_IDLE;
            default: step <= ST_IDLE;
         endcase
      end
   end

   assign busy = (step != ST_IDLE);
   assign done = (step == ST_FIN);

   // R5
   fin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   fin_after_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_T3) |=> done);

   // R7
   busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R8
   op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(op_q));

endmodule

// File: rtl/xfer_regbank.sv
`timescale 1ns/1ps
module xfer_regbank #(
   parameter int NUM_REGS = 4,
   parameter int DATA_W   = 8,
   localparam int SEL_W   = $clog2(NUM_REGS + 1),
   localparam int CNT_W   = $clog2(NUM_REGS + 2)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       seed_en,
   input  logic [SEL_W-1:0]           seed_sel,
   input  logic [DATA_W-1:0]          seed_data,
   input  logic [NUM_REGS-1:0]        latch_n,
   input  logic [NUM_REGS-1:0]        drive_n,
   input  logic                       acc_latch_n,
   input  logic                       acc_drive_n,
   output logic [NUM_REGS*DATA_W-1:0] reg_flat,
   output logic [DATA_W-1:0]          acc_q,
   output logic [DATA_W-1:0]          bus_val,
   output logic [CNT_W-1:0]           bus_cnt
);

   logic [DATA_W-1:0]   rf [NUM_REGS];
   logic [DATA_W-1:0]   drv_val [NUM_REGS];
   logic [NUM_REGS-1:0] latch_prev;
   logic                acc_latch_prev;

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("DATA_W must be positive");
      end
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         assign drv_val[i] = drive_n[i] ? '0 : rf[i];
         assign reg_flat[i*DATA_W +: DATA_W] = rf[i];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rf[i]         <= '0;
               latch_prev[i] <= 1'b1;
            end else begin
               latch_prev[i] <= latch_n[i];
               if (latch_prev[i] && !latch_n[i])
                  rf[i] <= bus_val;
               else if (seed_en && seed_sel == SEL_W'(i))
                  rf[i] <= seed_data;
            end
         end
      end
   endgenerate

   // wired bus: floats to zero when nothing drives it
   always_comb begin
      bus_val = acc_drive_n ? '0 : acc_q;
      bus_cnt = CNT_W'(!acc_drive_n);
      for (int i = 0; i < NUM_REGS; i++) begin
         bus_val = bus_val | drv_val[i];
         bus_cnt = bus_cnt + CNT_W'(!drive_n[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q          <= '0;
         acc_latch_prev <= 1'b1;
      end else begin
         acc_latch_prev <= acc_latch_n;
         if (acc_latch_prev && !acc_latch_n)
            acc_q <= bus_val;
         else if (seed_en && seed_sel == SEL_W'(NUM_REGS))
            acc_q <= seed_data;
      end
   end

   // R11
   single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cnt <= CNT_W'(1));

   // R9
   acc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_latch_prev && !acc_latch_n) |=> (acc_q == $past(bus_val)));

endmodule

// File: rtl/xfer_microseq.sv
`timescale 1ns/1ps
module xfer_microseq
   import xfer_pkg::*;
#(
   parameter int NUM_REGS = 4,
   parameter int TARGET   = 0,
   localparam int CW      = 3 * NUM_REGS + STROBE_COUNT
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          opcode,
   output logic [CW-1:0] ctrl_n,
   output logic          busy,
   output logic          done
);

   step_e step;
   logic  op_q;

   xfer_stepper u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .op    (opcode),
      .step  (step),
      .op_q  (op_q),
      .busy  (busy),
      .done  (done)
   );

   xfer_microstore #(
      .NUM_REGS (NUM_REGS),
      .TARGET   (TARGET)
   ) u_store (
      .step   (step),
      .op     (op_q),
      .word_n (ctrl_n)
   );

   // R2
   idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ctrl_n == '1));

   // R3
   first_step_one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($countones(~ctrl_n) == 1));

   // R4
   at_most_two_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~ctrl_n) <= 2);

   // R5
   done_word_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ctrl_n == '1));

endmodule

// File: tb/sim_xfer_microseq.sv
`timescale 1ns/1ps
module sim_xfer_microseq;

   localparam int N  = 4;
   localparam int W  = 8;
   localparam int CW = 3 * N + 6;

   localparam logic [CW-1:0] REST   = 18'h3FFFF;
   localparam logic [CW-1:0] LD_T1  = 18'h3DFFF;
   localparam logic [CW-1:0] LD_T2  = 18'h3DFFD;
   localparam logic [CW-1:0] SV_T1  = 18'h3FFFE;
   localparam logic [CW-1:0] SV_T2  = 18'h1FFFE;

   typedef struct {
      logic [CW-1:0] w;
      logic          b;
      logic          d;
      int            req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n, start, opcode;
   logic [CW-1:0] ctrl_n;
   logic          busy, done;

   logic          seed_en;
   logic [2:0]    seed_sel;
   logic [W-1:0]  seed_data;
   logic [N-1:0]  lat_n, drv_n;
   logic [N*W-1:0] reg_flat;
   logic [W-1:0]  acc_q, bus_val;
   logic [2:0]    bus_cnt;

   exp_t q[$];
   int   vecs  = 0;
   int   fails = 0;

   always #10 clk = ~clk;

   xfer_microseq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .ctrl_n(ctrl_n), .busy(busy), .done(done)
   );

   always_comb begin
      for (int i = 0; i < N; i++) begin
         lat_n[i] = ctrl_n[CW-1-i];
         drv_n[i] = ctrl_n[CW-1-N-i];
      end
   end

   xfer_regbank #(.NUM_REGS(N), .DATA_W(W)) u_bank (
      .clk(clk), .rst_n(rst_n), .seed_en(seed_en), .seed_sel(seed_sel),
      .seed_data(seed_data), .latch_n(lat_n), .drive_n(drv_n),
      .acc_latch_n(ctrl_n[1]), .acc_drive_n(ctrl_n[0]),
      .reg_flat(reg_flat), .acc_q(acc_q), .bus_val(bus_val), .bus_cnt(bus_cnt)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [CW-1:0] act, input logic [CW-1:0] exp);
      vecs++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor: one queued expectation per clock
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(ctrl_n == e.w, $sformatf("R%0d", e.req), "word", ctrl_n, e.w);
            check(busy == e.b && done == e.d, $sformatf("R%0d", e.req),
                  "busy/done", {busy, done}, {e.b, e.d});
            // R11 single driver at every monitored step
            check(bus_cnt <= 3'd1, "R11", "bus drivers", bus_cnt, 1);
         end
      end
   end

   task automatic push(input logic [CW-1:0] w, input logic b, input logic d,
                       input int req);
      exp_t e;
      e.w = w; e.b = b; e.d = d; e.req = req;
      q.push_back(e);
   endtask

   task automatic drain();
      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic seed(input logic [2:0] sel, input logic [W-1:0] val);
      @(negedge clk);
      seed_en = 1'b1; seed_sel = sel; seed_data = val;
      @(negedge clk);
      seed_en = 1'b0;
   endtask

   // driver: start one sequence, optionally poke start/opcode while busy
   task automatic run_op(input logic op, input bit poke);
      @(negedge clk);
      start = 1'b1; opcode = op;
      if (op) begin
         push(SV_T1, 1, 0, 6);   // R6
         push(SV_T2, 1, 0, 6);   // R6
      end else begin
         push(LD_T1, 1, 0, 3);   // R3
         push(LD_T2, 1, 0, 4);   // R4
      end
      push(REST, 1, 0, 5);       // R5 third step
      push(REST, 1, 1, 5);       // R5 done pulse
      push(REST, 0, 0, 7);       // R7 back to idle, pokes ignored
      @(negedge clk);
      start  = poke;
      opcode = ~op;              // R8 opcode change mid-sequence
      repeat (3) @(negedge clk);
      start = 1'b0;
      drain();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; opcode = 1'b0;
      seed_en = 1'b0; seed_sel = '0; seed_data = '0;
      repeat (3) @(negedge clk);
      // R1 during reset
      check(ctrl_n == REST && !busy && !done, "R1", "reset state",
            ctrl_n, REST);
      rst_n = 1'b1;
      @(negedge clk);
      check(ctrl_n == REST && !busy && !done, "R1", "after reset",
            ctrl_n, REST);

      // R2 idle with no start
      push(REST, 0, 0, 2); push(REST, 0, 0, 2); push(REST, 0, 0, 2);
      drain();

      // R9 load copies R0 into accumulator
      seed(3'd0, 8'h5A);
      seed(3'd4, 8'h00);
      run_op(1'b0, 1'b0);
      check(acc_q == 8'h5A, "R9", "acc after load", acc_q, 8'h5A);
      check(reg_flat[W-1:0] == 8'h5A, "R9", "R0 after load",
            reg_flat[W-1:0], 8'h5A);

      // R10 save copies accumulator into R0
      seed(3'd4, 8'hC3);
      run_op(1'b1, 1'b0);
      check(reg_flat[W-1:0] == 8'hC3, "R10", "R0 after save",
            reg_flat[W-1:0], 8'hC3);
      check(acc_q == 8'hC3, "R10", "acc after save", acc_q, 8'hC3);

      // R7 R8 load with start/opcode disturbed while busy
      seed(3'd0, 8'h21);
      seed(3'd1, 8'h77);
      run_op(1'b0, 1'b1);
      check(acc_q == 8'h21, "R8", "acc after disturbed load", acc_q, 8'h21);
      check(reg_flat[2*W-1:W] == 8'h77, "R11", "R1 untouched",
            reg_flat[2*W-1:W], 8'h77);

      // R7 R8 save with start/opcode disturbed while busy
      seed(3'd4, 8'h9E);
      run_op(1'b1, 1'b1);
      check(reg_flat[W-1:0] == 8'h9E, "R10", "R0 after disturbed save",
            reg_flat[W-1:0], 8'h9E);
      check(acc_q == 8'h9E, "R8", "acc after disturbed save", acc_q, 8'h9E);

      // back-to-back sequences
      run_op(1'b0, 1'b0);
      run_op(1'b1, 1'b0);
      check(!busy && ctrl_n == REST, "R2", "idle at end", ctrl_n, REST);

      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

endmodule